// File: doc/BRIEF.md
# Intermittent-Aware Sensor Node Sequencer

This block is the control core of a sensor node that runs from harvested energy with no battery. It orders the node's work into indivisible operations (take one sample, process it, send the result) and returns to a low-power idle state between them. A three-bit one-hot task flag records which operation is due next. An operation may start only when the digitised stored-energy level is strictly above that operation's own threshold, so each operation begins with enough charge to finish.

Processing and sending are the long operations. They keep running only while the energy stays above a safe-margin threshold. If the charge sags to that margin first, the sequencer drops back to idle and leaves the flag as it was, so the same work starts again once the store has recharged. A periodic sampling tick queues a new sample when no work is pending. A power-scarce interrupt overrides everything else and sends the sequencer into a save state, which ends when the save unit reports completion. Every operation is started by a single-cycle strobe, and each operation unit answers with a single-cycle done pulse.

Top module: `enode_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `state` = 0 (idle), `task_flag` = 000 and all four start strobes low.
- R2: `state` codes are 0 idle, 1 sample, 2 process, 3 send, 4 save. `task_flag` values are 100 sample due, 010 process due, 001 send due and 000 nothing due, and at most one flag bit is ever set.
- R3: From idle, the sequencer moves to the state that `task_flag` selects only if `energy` is strictly greater than that state's threshold (`thr_sample`, `thr_process`, `thr_send`). Otherwise, and whenever the flag is 000, it stays idle. The state changes at the first clock edge that sees the condition.
- R4: In the sample state, a `sample_done` pulse returns the sequencer to idle and sets the flag to 010.
- R5: In the process or send state, with no done pulse, the sequencer stays in that state while `energy` > `thr_safe`. When `energy` <= `thr_safe` it returns to idle and leaves the flag unchanged.
- R6: In the process state, `process_done` returns to idle and sets the flag to 001 if `need_send` is high, or to 000 if it is low.
- R7: In the send state, `send_done` returns to idle and sets the flag to 000.
- R8: `tick` sets the flag to 100 only when the flag is 000. With any other flag value it has no effect.
- R9: `pwr_low` moves the sequencer to the save state at the next edge from any state, and that edge leaves the flag unchanged. It takes priority over `tick`, done pulses and normal transitions. In the save state, `save_done` with `pwr_low` low returns to idle.
- R10: Each start strobe is high for exactly the first cycle of its state and never in any other cycle. A save state held by a continuing `pwr_low` raises no second `start_save`.
- R11: A done pulse from a unit whose state is not current has no effect on `state` or `task_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| energy | input | ENERGY_W | Digitised stored-energy level |
| thr_sample | input | ENERGY_W | Energy needed to start a sample |
| thr_process | input | ENERGY_W | Energy needed to start processing |
| thr_send | input | ENERGY_W | Energy needed to start sending |
| thr_safe | input | ENERGY_W | Safe margin; long operations stop at or below it |
| tick | input | 1 | Sampling-timer tick |
| pwr_low | input | 1 | Power-scarce interrupt |
| sample_done | input | 1 | One-cycle completion from the sampling unit |
| process_done | input | 1 | One-cycle completion from the processing unit |
| need_send | input | 1 | Qualifies `process_done`: result must be sent |
| send_done | input | 1 | One-cycle completion from the sending unit |
| save_done | input | 1 | One-cycle completion from the save unit |
| start_sample | output | 1 | Start pulse for the sampling unit |
| start_process | output | 1 | Start pulse for the processing unit |
| start_send | output | 1 | Start pulse for the sending unit |
| start_save | output | 1 | Start pulse for the save unit |
| state | output | 3 | Current state code |
| task_flag | output | 3 | Next-task one-hot flag |

## Verification
The bench sets the energy exactly equal to each threshold and then one step above it, because a design that used >= instead of > would dispatch one cycle early. It drops the energy to the safe margin during processing and during sending, which catches a design that clears the flag on an early exit (the work would be lost) or ignores the margin (the node would brown out mid-operation). It raises `pwr_low` together with a done pulse and together with a tick, which exposes a design that lets a normal transition or flag write win over the interrupt. It also holds `pwr_low` for several cycles to catch a repeated save strobe. Ticks are applied while work is pending, and done pulses are sent in the wrong state, to show that neither has any effect.

// File: rtl/enode_pkg.sv
package enode_pkg;

    localparam int STATE_W = 3;
    localparam int FLAG_W  = 3;
    localparam int NUM_OPS = 3;   // gated operations: sample, process, send

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE    = 3'd0,
        ST_SAMPLE  = 3'd1,
        ST_PROCESS = 3'd2,
        ST_SEND    = 3'd3,
        ST_SAVE    = 3'd4
    } node_state_e;

    // One-hot task flag; bit order is part of the external encoding.
    typedef struct packed {
        logic sample;
        logic process;
        logic send;
    } task_flag_t;

    localparam task_flag_t FLAG_NONE    = '{sample: 1'b0, process: 1'b0, send: 1'b0};
    localparam task_flag_t FLAG_SAMPLE  = '{sample: 1'b1, process: 1'b0, send: 1'b0};
    localparam task_flag_t FLAG_PROCESS = '{sample: 1'b0, process: 1'b1, send: 1'b0};
    localparam task_flag_t FLAG_SEND    = '{sample: 1'b0, process: 1'b0, send: 1'b1};

    typedef struct packed {
        logic sample;
        logic process;
        logic send;
        logic save;
    } start_strobe_t;

    typedef struct packed {
        logic sample;
        logic process;
        logic send;
        logic save;
    } done_pulse_t;

    // Index of each gated operation inside the comparator array.
    localparam int OP_SAMPLE  = 0;
    localparam int OP_PROCESS = 1;
    localparam int OP_SEND    = 2;

    function automatic logic flag_is_none(input task_flag_t f);
        return (f == FLAG_NONE);
    endfunction

    function automatic node_state_e op_to_state(input int op);
        node_state_e s;
        case (op)
            OP_SAMPLE:  s = ST_SAMPLE;
            OP_PROCESS: s = ST_PROCESS;
            default:    s = ST_SEND;
        endcase
        return s;
    endfunction

    function automatic start_strobe_t strobe_for(input node_state_e s);
        start_strobe_t r;
        r = '0;
        case (s)
            ST_SAMPLE:  r.sample  = 1'b1;
            ST_PROCESS: r.process = 1'b1;
            ST_SEND:    r.send    = 1'b1;
            ST_SAVE:    r.save    = 1'b1;
            default:    r         = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/enode_gate.sv
module enode_gate
    import enode_pkg::*;
#(
    parameter int ENERGY_W = 8
) (
    input  logic [ENERGY_W-1:0] energy,
    input  logic [ENERGY_W-1:0] thr_sample,
    input  logic [ENERGY_W-1:0] thr_process,
    input  logic [ENERGY_W-1:0] thr_send,
    input  logic [ENERGY_W-1:0] thr_safe,
    input  task_flag_t          flag,
    output logic [NUM_OPS-1:0]  launch_ok,
    output logic                above_safe
);

    logic [ENERGY_W-1:0] thr_arr [NUM_OPS];
    logic [NUM_OPS-1:0]  want;

    always_comb begin
        thr_arr[OP_SAMPLE]  = thr_sample;
        thr_arr[OP_PROCESS] = thr_process;
        thr_arr[OP_SEND]    = thr_send;
        want[OP_SAMPLE]     = flag.sample;
        want[OP_PROCESS]    = flag.process;
        want[OP_SEND]       = flag.send;
    end

    // One strict comparator per gated operation.
    for (genvar g = 0; g < NUM_OPS; g++) begin : g_cmp
        assign launch_ok[g] = want[g] && (energy > thr_arr[g]);
    end

    assign above_safe = (energy > thr_safe);

endmodule

// File: rtl/enode_flag.sv
module enode_flag
    import enode_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        pwr_low,
    input  logic        tick,
    input  node_state_e cur_state,
    input  done_pulse_t done,
    input  logic        need_send,
    output task_flag_t  flag
);

    task_flag_t flag_d;
    logic       op_write;

    always_comb begin
        flag_d   = flag;
        op_write = 1'b0;
        if (!pwr_low) begin
            case (cur_state)
                ST_SAMPLE: if (done.sample) begin
                    flag_d   = FLAG_PROCESS;
                    op_write = 1'b1;
                end
                ST_PROCESS: if (done.process) begin
                    flag_d   = need_send ? FLAG_SEND : FLAG_NONE;
                    op_write = 1'b1;
                end
                ST_SEND: if (done.send) begin
                    flag_d   = FLAG_NONE;
                    op_write = 1'b1;
                end
                default: op_write = 1'b0;
            endcase
            if (!op_write && tick && flag_is_none(flag)) begin
                flag_d = FLAG_SAMPLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= FLAG_NONE;
        end else begin
            flag <= flag_d;
        end
    end

endmodule

// File: rtl/enode_fsm.sv
module enode_fsm
    import enode_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               pwr_low,
    input  logic [NUM_OPS-1:0] launch_ok,
    input  logic               above_safe,
    input  done_pulse_t        done,
    output node_state_e        state,
    output start_strobe_t      strobe
);

    node_state_e nxt;

    always_comb begin
        nxt = state;
        if (pwr_low) begin
            nxt = ST_SAVE;
        end else begin
            case (state)
                ST_IDLE: begin
                    // Flag is one-hot, so at most one launch bit is set.
                    for (int op = 0; op < NUM_OPS; op++) begin
                        if (launch_ok[op]) nxt = op_to_state(op);
                    end
                end
                ST_SAMPLE:  if (done.sample) nxt = ST_IDLE;
                ST_PROCESS: if (done.process || !above_safe) nxt = ST_IDLE;
                ST_SEND:    if (done.send || !above_safe) nxt = ST_IDLE;
                ST_SAVE:    if (done.save) nxt = ST_IDLE;
                default:    nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            strobe <= '0;
        end else begin
            state  <= nxt;
            strobe <= (nxt != state) ? strobe_for(nxt) : '0;
        end
    end

endmodule

// File: rtl/enode_sequencer.sv
module enode_sequencer
    import enode_pkg::*;
#(
    parameter int ENERGY_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ENERGY_W-1:0] energy,
    input  logic [ENERGY_W-1:0] thr_sample,
    input  logic [ENERGY_W-1:0] thr_process,
    input  logic [ENERGY_W-1:0] thr_send,
    input  logic [ENERGY_W-1:0] thr_safe,
    input  logic                tick,
    input  logic                pwr_low,
    input  logic                sample_done,
    input  logic                process_done,
    input  logic                need_send,
    input  logic                send_done,
    input  logic                save_done,
    output logic                start_sample,
    output logic                start_process,
    output logic                start_send,
    output logic                start_save,
    output logic [2:0]          state,
    output logic [2:0]          task_flag
);

    task_flag_t         flag_q;
    node_state_e        state_q;
    start_strobe_t      strobe_q;
    done_pulse_t        done_in;
    logic [NUM_OPS-1:0] launch_ok;
    logic               above_safe;

    always_comb begin
        done_in.sample  = sample_done;
        done_in.process = process_done;
        done_in.send    = send_done;
        done_in.save    = save_done;
    end

    enode_gate #(
        .ENERGY_W (ENERGY_W)
    ) u_gate (
        .energy      (energy),
        .thr_sample  (thr_sample),
        .thr_process (thr_process),
        .thr_send    (thr_send),
        .thr_safe    (thr_safe),
        .flag        (flag_q),
        .launch_ok   (launch_ok),
        .above_safe  (above_safe)
    );

    enode_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .pwr_low    (pwr_low),
        .launch_ok  (launch_ok),
        .above_safe (above_safe),
        .done       (done_in),
        .state      (state_q),
        .strobe     (strobe_q)
    );

    enode_flag u_flag (
        .clk       (clk),
        .rst       (rst),
        .pwr_low   (pwr_low),
        .tick      (tick),
        .cur_state (state_q),
        .done      (done_in),
        .need_send (need_send),
        .flag      (flag_q)
    );

    assign state         = state_q;
    assign task_flag     = flag_q;
    assign start_sample  = strobe_q.sample;
    assign start_process = strobe_q.process;
    assign start_send    = strobe_q.send;
    assign start_save    = strobe_q.save;

endmodule

// File: rtl/enode_sequencer_chk.sv
module enode_sequencer_chk #(
    parameter int ENERGY_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic [ENERGY_W-1:0] energy,
    input logic [ENERGY_W-1:0] thr_sample,
    input logic [ENERGY_W-1:0] thr_safe,
    input logic                tick,
    input logic                pwr_low,
    input logic                sample_done,
    input logic                process_done,
    input logic                send_done,
    input logic                start_sample,
    input logic                start_process,
    input logic                start_send,
    input logic                start_save,
    input logic [2:0]          state,
    input logic [2:0]          task_flag
);

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (state == 3'd0 && task_flag == 3'b000)); // R1

    AST_FLAG_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(task_flag)); // R2

    AST_SAMPLE_GATED: assert property (@(posedge clk) disable iff (rst)
        (state == 3'd0 && !pwr_low && task_flag == 3'b100 && energy <= thr_sample)
        |=> (state == 3'd0)); // R3

    AST_SAMPLE_RETURN: assert property (@(posedge clk) disable iff (rst)
        (state == 3'd1 && sample_done && !pwr_low)
        |=> (state == 3'd0 && task_flag == 3'b010)); // R4

    AST_SAFE_EXIT: assert property (@(posedge clk) disable iff (rst)
        ((state == 3'd2 || state == 3'd3) && !process_done && !send_done
         && !pwr_low && energy <= thr_safe)
        |=> (state == 3'd0 && $stable(task_flag))); // R5

    AST_SEND_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (state == 3'd3 && send_done && !pwr_low)
        |=> (state == 3'd0 && task_flag == 3'b000)); // R7

    AST_TICK_QUEUES: assert property (@(posedge clk) disable iff (rst)
        (task_flag == 3'b000 && state == 3'd0 && tick && !pwr_low)
        |=> (task_flag == 3'b100)); // R8

    AST_PWR_SAVE: assert property (@(posedge clk) disable iff (rst)
        pwr_low |=> (state == 3'd4 && $stable(task_flag))); // R9

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({start_sample, start_process, start_send, start_save})); // R10

    AST_SAVE_NO_REPEAT: assert property (@(posedge clk) disable iff (rst)
        (state == 3'd4 && pwr_low) |=> !start_save); // R10

endmodule

bind enode_sequencer enode_sequencer_chk #(
    .ENERGY_W (ENERGY_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .energy        (energy),
    .thr_sample    (thr_sample),
    .thr_safe      (thr_safe),
    .tick          (tick),
    .pwr_low       (pwr_low),
    .sample_done   (sample_done),
    .process_done  (process_done),
    .send_done     (send_done),
    .start_sample  (start_sample),
    .start_process (start_process),
    .start_send    (start_send),
    .start_save    (start_save),
    .state         (state),
    .task_flag     (task_flag)
);

// File: tb/test_enode_sequencer.sv
module test_enode_sequencer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] energy = 8'd0;
    logic [7:0] thr_sample  = 8'd40;
    logic [7:0] thr_process = 8'd60;
    logic [7:0] thr_send    = 8'd100;
    logic [7:0] thr_safe    = 8'd30;
    logic tick = 0, pwr_low = 0, sample_done = 0, process_done = 0;
    logic need_send = 0, send_done = 0, save_done = 0;
    logic start_sample, start_process, start_send, start_save;
    logic [2:0] state, task_flag;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;  // 125 MHz

    enode_sequencer i_enode_sequencer (
        .clk(clk), .rst(rst), .energy(energy),
        .thr_sample(thr_sample), .thr_process(thr_process),
        .thr_send(thr_send), .thr_safe(thr_safe),
        .tick(tick), .pwr_low(pwr_low),
        .sample_done(sample_done), .process_done(process_done),
        .need_send(need_send), .send_done(send_done), .save_done(save_done),
        .start_sample(start_sample), .start_process(start_process),
        .start_send(start_send), .start_save(start_save),
        .state(state), .task_flag(task_flag)
    );

    // Vector: {req[3:0], energy[7:0], ctrl[6:0], exp_state[2:0], exp_flag[2:0], exp_strobe[3:0]}
    // ctrl = {tick, pwr_low, sample_done, process_done, send_done, need_send, save_done}
    // strobe = {sample, process, send, save}
    localparam int NV = 31;
    localparam logic [28:0] VECS [NV] = '{
        {4'd3,  8'd50,  7'b0000000, 3'd0, 3'b000, 4'b0000}, // R3 nothing due
        {4'd8,  8'd50,  7'b1000000, 3'd0, 3'b100, 4'b0000}, // R8 tick queues sample
        {4'd3,  8'd40,  7'b0000000, 3'd0, 3'b100, 4'b0000}, // R3 equal, no start
        {4'd3,  8'd41,  7'b0000000, 3'd1, 3'b100, 4'b1000}, // R3 R10 sample starts
        {4'd10, 8'd41,  7'b0000000, 3'd1, 3'b100, 4'b0000}, // R10 single pulse
        {4'd4,  8'd41,  7'b1010000, 3'd0, 3'b010, 4'b0000}, // R4 done, tick ignored
        {4'd3,  8'd60,  7'b0000000, 3'd0, 3'b010, 4'b0000}, // R3 equal process thr
        {4'd3,  8'd61,  7'b0000000, 3'd2, 3'b010, 4'b0100}, // R3 process starts
        {4'd5,  8'd31,  7'b0000000, 3'd2, 3'b010, 4'b0000}, // R5 above safe, stays
        {4'd5,  8'd30,  7'b0000000, 3'd0, 3'b010, 4'b0000}, // R5 safe exit keeps flag
        {4'd5,  8'd90,  7'b0000000, 3'd2, 3'b010, 4'b0100}, // R5 resumes
        {4'd6,  8'd90,  7'b0001010, 3'd0, 3'b001, 4'b0000}, // R6 send required
        {4'd3,  8'd100, 7'b0000000, 3'd0, 3'b001, 4'b0000}, // R3 equal send thr
        {4'd3,  8'd200, 7'b0000000, 3'd3, 3'b001, 4'b0010}, // R3 send starts
        {4'd8,  8'd200, 7'b1000000, 3'd3, 3'b001, 4'b0000}, // R8 tick ignored
        {4'd5,  8'd25,  7'b0000000, 3'd0, 3'b001, 4'b0000}, // R5 send safe exit
        {4'd5,  8'd150, 7'b0000000, 3'd3, 3'b001, 4'b0010}, // R5 send resumes
        {4'd7,  8'd150, 7'b0000100, 3'd0, 3'b000, 4'b0000}, // R7 send done clears
        {4'd8,  8'd150, 7'b1000000, 3'd0, 3'b100, 4'b0000}, // R8 tick
        {4'd3,  8'd150, 7'b0000000, 3'd1, 3'b100, 4'b1000}, // R3 sample
        {4'd9,  8'd150, 7'b0110000, 3'd4, 3'b100, 4'b0001}, // R9 beats sample done
        {4'd10, 8'd150, 7'b0100000, 3'd4, 3'b100, 4'b0000}, // R10 no re-strobe
        {4'd9,  8'd150, 7'b0000001, 3'd0, 3'b100, 4'b0000}, // R9 save done
        {4'd3,  8'd150, 7'b0000000, 3'd1, 3'b100, 4'b1000}, // R3 sample again
        {4'd4,  8'd150, 7'b0010000, 3'd0, 3'b010, 4'b0000}, // R4
        {4'd3,  8'd150, 7'b0000000, 3'd2, 3'b010, 4'b0100}, // R3 process
        {4'd6,  8'd150, 7'b0001000, 3'd0, 3'b000, 4'b0000}, // R6 no send needed
        {4'd9,  8'd150, 7'b1100000, 3'd4, 3'b000, 4'b0001}, // R9 beats tick
        {4'd9,  8'd150, 7'b0000001, 3'd0, 3'b000, 4'b0000}, // R9 back to idle
        {4'd3,  8'd255, 7'b0000000, 3'd0, 3'b000, 4'b0000}, // R3 flag 000 stays idle
        {4'd11, 8'd255, 7'b0011101, 3'd0, 3'b000, 4'b0000}  // R11 stray done pulses
    };

    task automatic check(input string req, input logic [2:0] es,
                         input logic [2:0] ef, input logic [3:0] eb);
        logic [3:0] ab;
        ab = {start_sample, start_process, start_send, start_save};
        checks++;
        if (state !== es || task_flag !== ef || ab !== eb) begin
            errors++;
            $display("FAIL %s: state=%0d flag=%b strobe=%b, expected state=%0d flag=%b strobe=%b",
                     req, state, task_flag, ab, es, ef, eb);
        end
    endtask

    task automatic drive(input logic [7:0] e, input logic [6:0] c);
        @(negedge clk);
        energy = e;
        {tick, pwr_low, sample_done, process_done, send_done, need_send, save_done} = c;
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(8 * 20000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run incomplete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        #2;
        check("R1", 3'd0, 3'b000, 4'b0000);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [28:0] v;
            v = VECS[i];
            drive(v[24:17], v[16:10]);
            check($sformatf("R%0d (vector %0d)", v[28:25], i), v[9:7], v[6:4], v[3:0]);
        end

        // R9: save from idle with work pending, flag kept
        drive(8'd0, 7'b1000000);
        check("R8", 3'd0, 3'b100, 4'b0000);
        drive(8'd0, 7'b0100000);
        check("R9", 3'd4, 3'b100, 4'b0001);
        drive(8'd0, 7'b0000001);
        check("R9", 3'd0, 3'b100, 4'b0000);

        // R1 reset mid-operation
        drive(8'd255, 7'b0000000);
        check("R3", 3'd1, 3'b100, 4'b1000);
        @(negedge clk);
        rst = 1'b1;
        energy = 8'd0;
        @(posedge clk);
        #2;
        check("R1", 3'd0, 3'b000, 4'b0000);
        @(negedge clk);
        rst = 1'b0;
        drive(8'd0, 7'b0000000);
        check("R1", 3'd0, 3'b000, 4'b0000);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule